// File: doc/BRIEF.md
# Control-Word Integer Arithmetic and Logic Unit

This block is the combinational execute stage of a small pipelined 32-bit integer core. It does not see opcodes. The decode stage hands it a set of already-decoded control fields together with two operands. From these it produces one result word and three comparison flags, and the branch logic of the core reads those flags.

Four units work side by side. An adder runs on operand 1 and a preprocessed operand 2. The preprocessor can pass operand 2 unchanged, invert it, move its low half up by 16 bits, or replace it with zero. The adder's carry-in follows the invert choice, so subtraction needs no separate path. A logic unit produces AND, OR, NOR, XOR or the preprocessed operand. A barrel shifter shifts operand 2 by a 5-bit amount. A comparator drives the set-on-less-than result and the flags.

A final select picks one unit's output for the result word. Nothing is stored inside the block, so every output follows its inputs in the same cycle.

Top module: `int_alu`

## Requirements
- R1: Operand-2 preprocessing by `op2_sel` (addressed through the adder, with carry-in, and the logic unit): 00 passes `b_in`, 01 gives its bitwise inverse, 10 gives `b_in[15:0]` followed by 16 zero bits, and 11 gives zero.
- R2: The adder computes `a_in` + preprocessed operand + `op2_sel[0]`. With 01 it therefore yields `a_in - b_in`, and with 11 it yields `a_in + 1`.
- R3: The logic unit uses `logic_sel` to pick the output: 00 gives AND, 01 gives OR, 10 gives XOR, and 11 gives the preprocessed operand 2. Each operation combines `a_in` with the preprocessed operand 2.
- R4: When `logic_sel` is 01, `logic_inv` high turns the OR result into NOR. For every other `logic_sel` value, `logic_inv` has no effect.
- R5: The shifter shifts `b_in` by `shamt` (0 to 31) according to `shift_sel`. When `shift_sel[1]` is 0 it shifts left logically, 10 shifts right logically, and 11 shifts right arithmetically.
- R6: When `en_slt` is high, the result is 1 if `a_in` is less than `b_in` and 0 otherwise, with all upper bits zero. The comparison is signed when `slt_uns` is 0 and unsigned when it is 1.
- R7: The result is selected in this priority order: set-on-less-than when `en_slt` is high; otherwise the logic unit when `en_logic` is high; otherwise the adder when `en_arith` is high; otherwise the shifter.
- R8: `flag_neg` equals bit 31 of `a_in`, whatever the control inputs are.
- R9: `flag_eq` is high exactly when `a_in` equals `b_in`. It does not depend on `op2_sel`.
- R10: `flag_lt` is high when `a_in` is less than `b_in`, signed or unsigned according to `slt_uns`. It is correct at the most-negative and most-positive operand values.
- R11: An upper-immediate load uses `op2_sel` = 10, `en_arith` = 1 and `a_in` = 0, and yields the low half of `b_in` moved to the upper half.
- R12: All outputs are combinational. A change on any input shows up on the outputs in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 32 | Operand 1 |
| b_in | input | 32 | Operand 2 (also the value that is shifted) |
| op2_sel | input | 2 | Operand-2 preprocessing select; bit 0 is also the adder carry-in |
| logic_sel | input | 2 | Logic operation select |
| logic_inv | input | 1 | Inverts the OR result to give NOR |
| shift_sel | input | 2 | Shift direction and fill |
| shamt | input | 5 | Shift distance |
| en_slt | input | 1 | Selects the set-on-less-than result |
| slt_uns | input | 1 | Makes the comparison unsigned |
| en_logic | input | 1 | Selects the logic unit result |
| en_arith | input | 1 | Selects the adder result |
| res | output | 32 | Result word |
| flag_neg | output | 1 | Operand 1 is negative |
| flag_eq | output | 1 | Operands are equal |
| flag_lt | output | 1 | Operand 1 is less than operand 2 |

## Verification
Two functions of this block can act in the same cycle. First, the result select and the comparison flags are always live together. Second, several unit enables can be raised at once.

The bench provokes both. It raises `en_slt`, `en_logic` and `en_arith` together, and it runs arithmetic and logic operations on operand pairs that sit at the signed and unsigned extremes. In each case it judges the result word against the priority order and, from the same applied vector, judges all three flags against an independent model.

// File: rtl/alu_pkg.sv
package alu_pkg;
    localparam int DATA_W  = 32;
    localparam int HALF_W  = DATA_W / 2;

    typedef enum logic [1:0] {
        OP2_PASS = 2'b00,
        OP2_INV  = 2'b01,
        OP2_HIGH = 2'b10,
        OP2_ZERO = 2'b11
    } op2_mode_e;

    typedef enum logic [1:0] {
        LG_AND  = 2'b00,
        LG_OR   = 2'b01,
        LG_XOR  = 2'b10,
        LG_PASS = 2'b11
    } logic_mode_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'b00,
        SH_LEFT1 = 2'b01,
        SH_RLOG  = 2'b10,
        SH_RARI  = 2'b11
    } shift_mode_e;

    typedef enum logic [1:0] {
        SRC_SHIFT = 2'b00,
        SRC_ADD   = 2'b01,
        SRC_LOGIC = 2'b10,
        SRC_SLT   = 2'b11
    } res_src_e;
endpackage

// File: rtl/alu_opnd_prep.sv
module alu_opnd_prep
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] b,
    input  logic [1:0]   sel,
    output logic [W-1:0] bp
);
    localparam int H = W / 2;

    always_comb begin
        unique case (op2_mode_e'(sel))
            OP2_PASS: bp = b;
            OP2_INV:  bp = ~b;
            OP2_HIGH: bp = {b[H-1:0], {H{1'b0}}};
            OP2_ZERO: bp = '0;
            default:  bp = '0;
        endcase
    end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] bp,
    input  logic         cin,
    output logic [W-1:0] sum
);
    logic [W:0] full;
    always_comb full = {1'b0, a} + {1'b0, bp} + {{W{1'b0}}, cin};
    assign sum = full[W-1:0];
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] bp,
    input  logic [1:0]   sel,
    input  logic         inv,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (logic_mode_e'(sel))
            LG_AND:  y = a & bp;
            LG_OR:   y = inv ? ~(a | bp) : (a | bp);
            LG_XOR:  y = a ^ bp;
            LG_PASS: y = bp;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
    import alu_pkg::*;
#(
    parameter int W  = 32,
    parameter int SW = 5
) (
    input  logic [W-1:0]  v,
    input  logic [SW-1:0] amt,
    input  logic [1:0]    sel,
    output logic [W-1:0]  y
);
    logic [W-1:0] stage [SW+1];
    logic         go_right;
    logic         fill;

    assign go_right = sel[1];
    assign fill     = (shift_mode_e'(sel) == SH_RARI) ? v[W-1] : 1'b0;
    assign stage[0] = v;

    for (genvar i = 0; i < SW; i++) begin : g_stage
        localparam int D = 1 << i;
        always_comb begin
            if (!amt[i])
                stage[i+1] = stage[i];
            else if (go_right)
                stage[i+1] = {{D{fill}}, stage[i][W-1:D]};
            else
                stage[i+1] = {stage[i][W-1-D:0], {D{1'b0}}};
        end
    end

    assign y = stage[SW];
endmodule

// File: rtl/alu_cmp.sv
module alu_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         uns,
    output logic         neg,
    output logic         eq,
    output logic         lt
);
    logic [W:0] diff;
    logic       lt_s;
    logic       lt_u;

    always_comb begin
        diff = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, 1'b1};
        lt_u = ~diff[W];
        lt_s = (a[W-1] != b[W-1]) ? a[W-1] : diff[W-1];
    end

    assign neg = a[W-1];
    assign eq  = (a == b);
    assign lt  = uns ? lt_u : lt_s;
endmodule

// File: rtl/int_alu.sv
module int_alu
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]         a_in,
    input  logic [W-1:0]         b_in,
    input  logic [1:0]           op2_sel,
    input  logic [1:0]           logic_sel,
    input  logic                 logic_inv,
    input  logic [1:0]           shift_sel,
    input  logic [$clog2(W)-1:0] shamt,
    input  logic                 en_slt,
    input  logic                 slt_uns,
    input  logic                 en_logic,
    input  logic                 en_arith,
    output logic [W-1:0]         res,
    output logic                 flag_neg,
    output logic                 flag_eq,
    output logic                 flag_lt
);
    localparam int SW = $clog2(W);

    logic [W-1:0] b_prep;
    logic [W-1:0] sum_y;
    logic [W-1:0] logic_y;
    logic [W-1:0] shift_y;
    res_src_e     src;

    alu_opnd_prep #(.W(W)) u_prep (
        .b(b_in), .sel(op2_sel), .bp(b_prep)
    );

    alu_addsub #(.W(W)) u_add (
        .a(a_in), .bp(b_prep), .cin(op2_sel[0]), .sum(sum_y)
    );

    alu_logic #(.W(W)) u_logic (
        .a(a_in), .bp(b_prep), .sel(logic_sel), .inv(logic_inv), .y(logic_y)
    );

    alu_shift #(.W(W), .SW(SW)) u_shift (
        .v(b_in), .amt(shamt), .sel(shift_sel), .y(shift_y)
    );

    alu_cmp #(.W(W)) u_cmp (
        .a(a_in), .b(b_in), .uns(slt_uns),
        .neg(flag_neg), .eq(flag_eq), .lt(flag_lt)
    );

    always_comb begin
        if (en_slt)        src = SRC_SLT;
        else if (en_logic) src = SRC_LOGIC;
        else if (en_arith) src = SRC_ADD;
        else               src = SRC_SHIFT;
    end

    always_comb begin
        unique case (src)
            SRC_SLT:   res = {{(W-1){1'b0}}, flag_lt};
            SRC_LOGIC: res = logic_y;
            SRC_ADD:   res = sum_y;
            SRC_SHIFT: res = shift_y;
            default:   res = '0;
        endcase
    end
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
    parameter int W = 32
) (
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic [1:0]   op2_sel,
    input logic         en_slt,
    input logic         slt_uns,
    input logic         en_logic,
    input logic         en_arith,
    input logic [W-1:0] res,
    input logic         flag_eq,
    input logic         flag_lt
);
    localparam int H = W / 2;

    always_comb begin
        if (en_slt)
            p_slt_upper_zero_r6: assert (res[W-1:1] == '0);
        if (flag_eq)
            p_eq_not_lt_r9: assert (!flag_lt);
        if (!slt_uns && a_in[W-1] && !b_in[W-1])
            p_signed_neg_lt_r10: assert (flag_lt);
        if (!en_slt && !en_logic && en_arith && op2_sel == 2'b10 && a_in == '0)
            p_upper_imm_r11: assert (res == {b_in[H-1:0], {H{1'b0}}});
        if (!en_slt && !en_logic && en_arith && op2_sel == 2'b01 && a_in == b_in)
            p_sub_self_zero_r2: assert (res == '0);
    end
endmodule

bind int_alu int_alu_chk #(.W(W)) u_chk (
    .a_in(a_in), .b_in(b_in), .op2_sel(op2_sel), .en_slt(en_slt),
    .slt_uns(slt_uns), .en_logic(en_logic), .en_arith(en_arith),
    .res(res), .flag_eq(flag_eq), .flag_lt(flag_lt)
);

// File: tb/int_alu_bench.sv
module int_alu_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] a_in = '0, b_in = '0;
    logic [1:0]  op2_sel = '0, logic_sel = '0, shift_sel = '0;
    logic        logic_inv = 0, en_slt = 0, slt_uns = 0, en_logic = 0, en_arith = 0;
    logic [4:0]  shamt = '0;
    logic [31:0] res;
    logic        flag_neg, flag_eq, flag_lt;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct packed {
        logic [31:0] res;
        logic        neg;
        logic        eq;
        logic        lt;
    } exp_t;

    exp_t  exp_q [$];
    string tag_q [$];

    always #10 clk = ~clk;

    int_alu u_int_alu (
        .a_in(a_in), .b_in(b_in), .op2_sel(op2_sel), .logic_sel(logic_sel),
        .logic_inv(logic_inv), .shift_sel(shift_sel), .shamt(shamt),
        .en_slt(en_slt), .slt_uns(slt_uns), .en_logic(en_logic),
        .en_arith(en_arith), .res(res), .flag_neg(flag_neg),
        .flag_eq(flag_eq), .flag_lt(flag_lt)
    );

    function automatic exp_t model(
        input logic [31:0] a, input logic [31:0] b, input logic [1:0] os,
        input logic [1:0] ls, input logic li, input logic [1:0] ss,
        input logic [4:0] sh, input logic es, input logic us,
        input logic el, input logic ea);
        exp_t e;
        logic [31:0] bq, lg, sf, ad;
        logic lt;
        case (os)
            2'b00: bq = b;
            2'b01: bq = ~b;
            2'b10: bq = b << 16;
            default: bq = 32'd0;
        endcase
        ad = a + bq + {31'd0, os[0]};
        case (ls)
            2'b00: lg = a & bq;
            2'b01: lg = li ? ~(a | bq) : (a | bq);
            2'b10: lg = a ^ bq;
            default: lg = bq;
        endcase
        if (!ss[1])       sf = b << sh;
        else if (!ss[0])  sf = b >> sh;
        else              sf = $unsigned($signed(b) >>> sh);
        lt = us ? (a < b) : ($signed(a) < $signed(b));
        e.neg = a[31];
        e.eq  = (a == b);
        e.lt  = lt;
        if (es)      e.res = {31'd0, lt};
        else if (el) e.res = lg;
        else if (ea) e.res = ad;
        else         e.res = sf;
        return e;
    endfunction

    task automatic drive(input string tag, input logic [31:0] a, input logic [31:0] b,
                         input logic [1:0] os, input logic [1:0] ls, input logic li,
                         input logic [1:0] ss, input logic [4:0] sh, input logic es,
                         input logic us, input logic el, input logic ea);
        @(negedge clk);
        a_in = a; b_in = b; op2_sel = os; logic_sel = ls; logic_inv = li;
        shift_sel = ss; shamt = sh; en_slt = es; slt_uns = us;
        en_logic = el; en_arith = ea;
        exp_q.push_back(model(a, b, os, ls, li, ss, sh, es, us, el, ea));
        tag_q.push_back(tag);
    endtask

    always @(posedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (res !== e.res || flag_neg !== e.neg || flag_eq !== e.eq || flag_lt !== e.lt) begin
                fails++;
                $display("FAIL %s: res=%h n=%b e=%b l=%b expected res=%h n=%b e=%b l=%b",
                         t, res, flag_neg, flag_eq, flag_lt, e.res, e.neg, e.eq, e.lt);
            end
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        rst = 0;
        // reset / idle: all zero inputs give zero shift output
        drive("R7 idle", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R1 / R2 adder with each preprocessing mode
        drive("R1 pass add", 32'd100, 32'd23, 2'b00, 0, 0, 0, 0, 0, 0, 0, 1);
        drive("R2 sub", 32'd100, 32'd23, 2'b01, 0, 0, 0, 0, 0, 0, 0, 1);
        drive("R2 sub wrap", 32'd0, 32'd1, 2'b01, 0, 0, 0, 0, 0, 0, 0, 1);
        drive("R1 high add", 32'h10, 32'h0000_ABCD, 2'b10, 0, 0, 0, 0, 0, 0, 0, 1);
        drive("R2 zero plus one", 32'h7FFF_FFFF, 32'h1234, 2'b11, 0, 0, 0, 0, 0, 0, 0, 1);
        drive("R11 upper imm", 32'd0, 32'hDEAD_BEEF, 2'b10, 0, 0, 0, 0, 0, 0, 0, 1);
        // R3 / R4 logic
        drive("R3 and", 32'hF0F0_FF00, 32'h0FF0_F0F0, 2'b00, 2'b00, 0, 0, 0, 0, 0, 1, 0);
        drive("R3 or", 32'hF0F0_FF00, 32'h0FF0_F0F0, 2'b00, 2'b01, 0, 0, 0, 0, 0, 1, 0);
        drive("R3 xor", 32'hF0F0_FF00, 32'h0FF0_F0F0, 2'b00, 2'b10, 0, 0, 0, 0, 0, 1, 0);
        drive("R3 pass high", 32'h1, 32'h0000_5A5A, 2'b10, 2'b11, 0, 0, 0, 0, 0, 1, 0);
        drive("R4 nor", 32'hF0F0_FF00, 32'h0FF0_F0F0, 2'b00, 2'b01, 1, 0, 0, 0, 0, 1, 0);
        drive("R4 inv ignored xor", 32'hF0F0_FF00, 32'h0FF0_F0F0, 2'b00, 2'b10, 1, 0, 0, 0, 0, 1, 0);
        drive("R4 inv ignored and", 32'hFFFF_0000, 32'h0F0F_0F0F, 2'b00, 2'b00, 1, 0, 0, 0, 0, 1, 0);
        // R5 shifter
        drive("R5 sll", 0, 32'h8000_0001, 0, 0, 0, 2'b00, 5'd4, 0, 0, 0, 0);
        drive("R5 sll alt", 0, 32'h0000_0003, 0, 0, 0, 2'b01, 5'd31, 0, 0, 0, 0);
        drive("R5 srl", 0, 32'h8000_0000, 0, 0, 0, 2'b10, 5'd31, 0, 0, 0, 0);
        drive("R5 sra", 0, 32'h8000_0F00, 0, 0, 0, 2'b11, 5'd8, 0, 0, 0, 0);
        drive("R5 sra zero amt", 0, 32'h8765_4321, 0, 0, 0, 2'b11, 5'd0, 0, 0, 0, 0);
        for (int k = 0; k < 32; k += 7)
            drive("R5 sweep", 0, 32'hC3A5_96F0, 0, 0, 0, 2'b11, 5'(k), 0, 0, 0, 0);
        // R6 / R10 compare extremes
        drive("R6 slt signed", 32'h8000_0000, 32'h7FFF_FFFF, 0, 0, 0, 0, 0, 1, 0, 0, 0);
        drive("R6 slt unsigned", 32'h8000_0000, 32'h7FFF_FFFF, 0, 0, 0, 0, 0, 1, 1, 0, 0);
        drive("R10 lt pos neg", 32'h7FFF_FFFF, 32'h8000_0000, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        drive("R10 lt unsigned", 32'h0000_0001, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, 1, 0, 1);
        drive("R10 lt same sign", 32'hFFFF_FFFE, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 1, 0, 0, 0);
        // R9 equality independent of op2_sel, R8 neg flag
        drive("R9 eq with inv sel", 32'h1234_5678, 32'h1234_5678, 2'b01, 0, 0, 0, 0, 0, 0, 0, 1);
        drive("R8 neg flag", 32'h8000_0001, 32'h5, 2'b11, 2'b11, 1, 2'b11, 5'd3, 0, 1, 1, 0);
        // R7 priority with several enables
        drive("R7 slt over all", 32'd3, 32'd9, 0, 2'b01, 0, 0, 0, 1, 0, 1, 1);
        drive("R7 logic over add", 32'd3, 32'd9, 0, 2'b10, 0, 0, 0, 0, 0, 1, 1);
        // R12 back to back vectors each judged in their own cycle
        drive("R12 step a", 32'd5, 32'd5, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        drive("R12 step b", 32'd6, 32'd5, 2'b01, 0, 0, 0, 0, 0, 0, 0, 1);
        @(negedge clk);
        while (exp_q.size() > 0) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule